// File: doc/BRIEF.md
# Unbuffered Serial Bit Port

This block gives a host a raw, bit-at-a-time path to and from the radio datapath for debug and evaluation. The frame buffers are bypassed. Two pins change role: one becomes a data pin that can face either direction, and the other becomes a data clock that the block generates. The data clock runs at 250 kHz with a 50% duty cycle. Its half period is derived from the system clock frequency.

When transmit is selected and switched on, the block first sends a synchronisation header on its own. The header is a run of zero preamble bits followed by the start-of-frame delimiter. The data clock stays low while the header goes out. After the header, the data clock starts. On every rising edge the block samples the host's data pin and forwards that bit to the modulator. The host is expected to update the pin on the falling edge. This continues until transmit is switched off or the transmit mode bit is cleared; no frame length ends it.

When receive is selected, the block drives the data pin and keeps the clock low until the demodulator reports a start-of-frame delimiter. It then clocks demodulated bits out to the host. The host samples on the rising edge. Clocking stops at a frame-end indication, and the block waits for the next delimiter. The delimiter-indicator and channel-clear signals pass through unchanged in every mode.

Top module: `serial_bypass_port`

## Requirements
- R1: After reset, `dclk`, `tx_stb`, `dat_oe` and `dat_out` are all low.
- R2: The mode comes from two bits, and the transmit bit wins when both are set. `dat_oe` is high exactly when the receive bit is set and the transmit bit is clear. `tx_stb` is low in the cycle after any cycle in which `dat_oe` is high.
- R3: While running, `dclk` has a period of 2*HALF system clocks and stays high for HALF of them. HALF = CLK_HZ/(2*BIT_HZ), which is 100 at the defaults (50 MHz, 250 kHz).
- R4: When transmit starts, the first PRE_BITS strobes on `tx_bit` carry 0. The next SFD_BITS strobes carry SFD_PATTERN, bit 0 first; the default is 8'hA7. `dclk` stays low for the whole header.
- R5: After the header, each rising edge of `dclk` samples `dat_in`. That value appears on `tx_bit`, and `tx_stb` is high in the same cycle that `dclk` first reads high.
- R6: Transmit keeps running until `tx_on` is low or the transmit bit is cleared. In the cycle after either condition is sampled, `dclk` is low, and no further strobes follow.
- R7: In receive mode, `dclk` stays low until `sfd_detect` is sampled high.
- R8: In receive, `dat_out` takes `demod_bit` on the edge that samples `sfd_detect` and again on each falling edge of `dclk`. It holds steady while `dclk` is high, and it is 0 whenever receive clocking is not running.
- R9: Sampling `frame_end` high while receive clocking is running forces `dclk` and `dat_out` low from the next cycle. The block then waits for another `sfd_detect` and resumes on it.
- R10: `sfd_ind_o` equals `sfd_ind_i` and `cca_o` equals `cca_i` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_serial | input | 1 | Transmit mode bit (priority) |
| cfg_rx_serial | input | 1 | Receive mode bit |
| tx_on | input | 1 | Transmit enable; low stops transmission |
| sfd_detect | input | 1 | Demodulator found a frame delimiter |
| frame_end | input | 1 | Demodulator signals end of frame |
| demod_bit | input | 1 | Current demodulated bit |
| sfd_ind_i | input | 1 | Delimiter indicator from the datapath |
| cca_i | input | 1 | Channel-clear indicator from the datapath |
| dat_in | input | 1 | Data pin, input side (host data in transmit) |
| dat_out | output | 1 | Data pin, output side (received bits) |
| dat_oe | output | 1 | Data pin drive enable |
| dclk | output | 1 | Generated data clock |
| tx_bit | output | 1 | Bit passed to the modulator |
| tx_stb | output | 1 | One-cycle strobe qualifying `tx_bit` |
| sfd_ind_o | output | 1 | Delimiter indicator to the pin |
| cca_o | output | 1 | Channel-clear indicator to the pin |

## Verification
Suppose the header bit index or its done flag is wrong. The strobe stream then departs from the zero run plus delimiter within one bit period of the fault, or the clock starts early while the header is still going out. Suppose instead the bit timer is off by one. A single rising-to-rising interval of `dclk` then shows it, so the first two data bits are enough to expose it. A stuck control state shows up in receive within one half period. Either the clock toggles before a delimiter arrives, or it stays high after a frame-end, or `dat_out` moves while the clock is high.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    MD_OFF,
    MD_TX,
    MD_RX
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_SYNC,
    ST_TX_DATA,
    ST_RX_WAIT,
    ST_RX_RUN
  } state_e;

  // System clocks per half period of the data clock.
  function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                              input int unsigned bit_hz);
    return clk_hz / (2 * bit_hz);
  endfunction

  // Transmit bit takes priority over receive bit.
  function automatic mode_e decode_mode(input logic tx_sel, input logic rx_sel);
    if (tx_sel) return MD_TX;
    if (rx_sel) return MD_RX;
    return MD_OFF;
  endfunction

  // Header bit at position idx: zeros first, then the delimiter LSB first.
  function automatic logic sync_bit(input int unsigned idx,
                                    input int unsigned pre_bits,
                                    input logic [31:0] pattern);
    logic [31:0] shifted;
    if (idx < pre_bits) return 1'b0;
    shifted = pattern >> (idx - pre_bits);
    return shifted[0];
  endfunction

  function automatic logic is_clocking(input state_e st);
    return (st == ST_TX_DATA) || (st == ST_RX_RUN);
  endfunction

  function automatic logic timer_active(input state_e st);
    return (st == ST_TX_SYNC) || (st == ST_TX_DATA) || (st == ST_RX_RUN);
  endfunction

endpackage

// File: rtl/sbp_bit_timer.sv
module sbp_bit_timer #(
  parameter int unsigned HALF = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ev_rise,
  output logic ev_wrap,
  output logic phase_high
);
  localparam int unsigned PERIOD = 2 * HALF;
  localparam int unsigned CW     = $clog2(PERIOD);

  logic [CW-1:0] cnt_q;

  assign ev_rise    = run && (cnt_q == CW'(HALF - 1));
  assign ev_wrap    = run && (cnt_q == CW'(PERIOD - 1));
  assign phase_high = run && (cnt_q >= CW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (ev_wrap) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sbp_sync_seq.sv
module sbp_sync_seq #(
  parameter int unsigned PRE_BITS    = 32,
  parameter int unsigned SFD_BITS    = 8,
  parameter logic [31:0] SFD_PATTERN = 32'h0000_00A7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic adv,
  output logic bit_o,
  output logic done_o
);
  localparam int unsigned TOTAL = PRE_BITS + SFD_BITS;
  localparam int unsigned IW    = $clog2(TOTAL + 1);

  logic [IW-1:0] idx_q;
  logic          done_q;

  assign bit_o  = sbp_pkg::sync_bit(32'(idx_q), PRE_BITS, SFD_PATTERN);
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (!active) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (adv && !done_q) begin
      if (idx_q == IW'(TOTAL - 1)) done_q <= 1'b1;
      else                         idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sbp_mode_fsm.sv
module sbp_mode_fsm
  import sbp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  mode_e  mode,
  input  logic   tx_on,
  input  logic   sfd_detect,
  input  logic   frame_end,
  input  logic   ev_wrap,
  input  logic   sync_done,
  output state_e state_q,
  output state_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (mode == MD_TX && tx_on) state_d = ST_TX_SYNC;
        else if (mode == MD_RX)     state_d = ST_RX_WAIT;
      end
      ST_TX_SYNC: begin
        if (mode != MD_TX || !tx_on)  state_d = ST_IDLE;
        else if (ev_wrap && sync_done) state_d = ST_TX_DATA;
      end
      ST_TX_DATA: begin
        if (mode != MD_TX || !tx_on) state_d = ST_IDLE;
      end
      ST_RX_WAIT: begin
        if (mode != MD_RX)   state_d = ST_IDLE;
        else if (sfd_detect) state_d = ST_RX_RUN;
      end
      ST_RX_RUN: begin
        if (mode != MD_RX)  state_d = ST_IDLE;
        else if (frame_end) state_d = ST_RX_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/serial_bypass_port.sv
module serial_bypass_port
  import sbp_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned BIT_HZ      = 250_000,
  parameter int unsigned PRE_BITS    = 32,
  parameter int unsigned SFD_BITS    = 8,
  parameter logic [31:0] SFD_PATTERN = 32'h0000_00A7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_tx_serial,
  input  logic cfg_rx_serial,
  input  logic tx_on,
  input  logic sfd_detect,
  input  logic frame_end,
  input  logic demod_bit,
  input  logic sfd_ind_i,
  input  logic cca_i,
  input  logic dat_in,
  output logic dat_out,
  output logic dat_oe,
  output logic dclk,
  output logic tx_bit,
  output logic tx_stb,
  output logic sfd_ind_o,
  output logic cca_o
);
  localparam int unsigned HALF_CYC = half_cycles(CLK_HZ, BIT_HZ);

  mode_e  cur_mode;
  state_e fsm_state;
  state_e fsm_next;
  logic   ev_rise, ev_wrap, phase_high;
  logic   sync_val, sync_done;
  logic   state_hold;
  logic   take_sample;
  logic   rx_start;
  logic   rx_shift;
  logic   tx_q, stb_q, rx_q;

  assign cur_mode   = decode_mode(cfg_tx_serial, cfg_rx_serial);
  assign state_hold = (fsm_next == fsm_state);

  sbp_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (cur_mode),
    .tx_on      (tx_on),
    .sfd_detect (sfd_detect),
    .frame_end  (frame_end),
    .ev_wrap    (ev_wrap),
    .sync_done  (sync_done),
    .state_q    (fsm_state),
    .state_d    (fsm_next)
  );

  sbp_bit_timer #(.HALF(HALF_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (timer_active(fsm_state)),
    .ev_rise    (ev_rise),
    .ev_wrap    (ev_wrap),
    .phase_high (phase_high)
  );

  sbp_sync_seq #(
    .PRE_BITS    (PRE_BITS),
    .SFD_BITS    (SFD_BITS),
    .SFD_PATTERN (SFD_PATTERN)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (fsm_state == ST_TX_SYNC),
    .adv    (ev_rise),
    .bit_o  (sync_val),
    .done_o (sync_done)
  );

  // Named events for the checker and for readability.
  assign take_sample = ev_rise && state_hold &&
                       (fsm_state == ST_TX_SYNC || fsm_state == ST_TX_DATA);
  assign rx_start    = (fsm_state == ST_RX_WAIT) && (fsm_next == ST_RX_RUN);
  assign rx_shift    = (fsm_state == ST_RX_RUN) && state_hold && ev_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= take_sample;
      if (take_sample)
        tx_q <= (fsm_state == ST_TX_SYNC) ? sync_val : dat_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rx_q <= 1'b0;
    else if (rx_start || rx_shift)   rx_q <= demod_bit;
    else if (fsm_next != ST_RX_RUN)  rx_q <= 1'b0;
  end

  assign dclk      = is_clocking(fsm_state) && phase_high;
  assign tx_bit    = tx_q;
  assign tx_stb    = stb_q;
  assign dat_out   = rx_q;
  assign dat_oe    = (cur_mode == MD_RX);
  assign sfd_ind_o = sfd_ind_i;
  assign cca_o     = cca_i;
endmodule

// File: rtl/serial_bypass_port_chk.sv
module serial_bypass_port_chk
  import sbp_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input state_e state_i,
  input logic   cfg_tx,
  input logic   cfg_rx,
  input logic   tx_on,
  input logic   frame_end,
  input logic   dclk,
  input logic   tx_stb,
  input logic   dat_out,
  input logic   dat_oe
);
  p_sync_clock_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_TX_SYNC) |-> !dclk);

  p_strobe_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_TX_DATA && $rose(dclk)) |-> tx_stb);

  p_stop_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx && !tx_on) |=> !dclk);

  p_wait_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_RX_WAIT) |-> !dclk);

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(dclk)) |-> $stable(dat_out));

  p_frame_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rx && !cfg_tx && frame_end) |=> (!dclk && !dat_out));

  p_rx_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |=> !tx_stb);
endmodule

bind serial_bypass_port serial_bypass_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state_i   (fsm_state),
  .cfg_tx    (cfg_tx_serial),
  .cfg_rx    (cfg_rx_serial),
  .tx_on     (tx_on),
  .frame_end (frame_end),
  .dclk      (dclk),
  .tx_stb    (tx_stb),
  .dat_out   (dat_out),
  .dat_oe    (dat_oe)
);

// File: tb/serial_bypass_port_tb.sv
module serial_bypass_port_tb;
  localparam int unsigned HALF    = 100;
  localparam int unsigned PRE     = 32;
  localparam int unsigned SFDN    = 8;
  localparam logic [7:0]  SFD_VAL = 8'hA7;
  localparam time         TCLK    = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_tx_serial = 1'b0, cfg_rx_serial = 1'b0, tx_on = 1'b0;
  logic sfd_detect = 1'b0, frame_end = 1'b0, demod_bit = 1'b0;
  logic sfd_ind_i = 1'b0, cca_i = 1'b0, dat_in = 1'b0;
  logic dat_out, dat_oe, dclk, tx_bit, tx_stb, sfd_ind_o, cca_o;

  int checks = 0;
  int failures = 0;
  int sync_left = 0;
  logic exp_tx[$];
  logic exp_rx[$];

  always #(TCLK/2) clk = ~clk;

  serial_bypass_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx_serial(cfg_tx_serial),
    .cfg_rx_serial(cfg_rx_serial), .tx_on(tx_on), .sfd_detect(sfd_detect),
    .frame_end(frame_end), .demod_bit(demod_bit), .sfd_ind_i(sfd_ind_i),
    .cca_i(cca_i), .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .dclk(dclk), .tx_bit(tx_bit), .tx_stb(tx_stb), .sfd_ind_o(sfd_ind_o),
    .cca_o(cca_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Transmit monitor: pops expected bits on each strobe.
  initial forever begin
    @(negedge clk);
    if (rst_n && tx_stb) begin
      if (exp_tx.size() == 0) chk(1'b0, "R6 unexpected strobe", 1, 0);
      else begin
        logic e;
        e = exp_tx.pop_front();
        if (sync_left > 0) begin
          chk(tx_bit == e, "R4 header bit", int'(tx_bit), int'(e));
          chk(dclk == 1'b0, "R4 clock low in header", int'(dclk), 0);
          sync_left--;
        end else begin
          chk(tx_bit == e, "R5 sampled host bit", int'(tx_bit), int'(e));
          chk(dclk == 1'b1, "R5 strobe with rising clock", int'(dclk), 1);
        end
      end
    end
  end

  // Receive monitor: host samples on the rising data clock.
  initial forever begin
    @(posedge dclk);
    @(negedge clk);
    if (dat_oe) begin
      if (exp_rx.size() == 0) chk(1'b0, "R8 unexpected rx clock", 1, 0);
      else begin
        logic e;
        e = exp_rx.pop_front();
        chk(dat_out == e, "R8 received bit", int'(dat_out), int'(e));
      end
    end
  end

  task automatic push_sync();
    for (int i = 0; i < PRE; i++) exp_tx.push_back(1'b0);
    for (int i = 0; i < SFDN; i++) exp_tx.push_back(SFD_VAL[i]);
    sync_left = PRE + SFDN;
  endtask

  task automatic host_tx(input logic [15:0] pat, input int n);
    time r1, f1, r2;
    dat_in = pat[0];
    exp_tx.push_back(pat[0]);
    for (int k = 1; k < n; k++) begin
      @(posedge dclk);
      if (k == 1) r1 = $time;
      if (k == 2) r2 = $time;
      @(negedge dclk);
      if (k == 1) f1 = $time;
      dat_in = pat[k];
      exp_tx.push_back(pat[k]);
    end
    @(posedge dclk);
    @(negedge clk);
    @(negedge clk);
    chk((f1 - r1) == HALF * TCLK, "R3 high time", int'((f1 - r1) / TCLK), HALF);
    chk((r2 - r1) == 2 * HALF * TCLK, "R3 period", int'((r2 - r1) / TCLK), 2 * HALF);
  endtask

  task automatic rx_frame(input logic [15:0] pat, input int n);
    demod_bit = pat[0];
    exp_rx.push_back(pat[0]);
    @(negedge clk) sfd_detect = 1'b1;
    @(negedge clk) sfd_detect = 1'b0;
    for (int k = 1; k < n; k++) begin
      @(posedge dclk);
      @(negedge clk);
      demod_bit = pat[k];
      exp_rx.push_back(pat[k]);
    end
    @(posedge dclk);
    @(negedge clk);
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    chk(dclk == 1'b0, "R9 clock low after frame end", int'(dclk), 0);
    chk(dat_out == 1'b0, "R9 data low after frame end", int'(dat_out), 0);
  endtask

  task automatic quiet(input int cyc, input string req);
    int hi = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (dclk) hi++;
    end
    chk(hi == 0, req, hi, 0);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dclk == 0 && tx_stb == 0 && dat_oe == 0 && dat_out == 0,
        "R1 reset outputs", int'({dclk, tx_stb, dat_oe, dat_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dclk == 0 && tx_stb == 0 && dat_oe == 0 && dat_out == 0,
        "R1 after release", int'({dclk, tx_stb, dat_oe, dat_out}), 0);

    // R10 pass-through
    sfd_ind_i = 1'b1; cca_i = 1'b0; #1;
    chk(sfd_ind_o == 1 && cca_o == 0, "R10 indicators", int'({sfd_ind_o, cca_o}), 2);

    // Transmit: header, then host data.
    cfg_tx_serial = 1'b1;
    push_sync();
    tx_on = 1'b1;
    wait (sync_left == 0);
    host_tx(16'b1011_0010_1110_0101, 12);
    sfd_ind_i = 1'b0; cca_i = 1'b1; #1;
    chk(sfd_ind_o == 0 && cca_o == 1, "R10 indicators in tx", int'({sfd_ind_o, cca_o}), 1);

    // R6: stop with tx_on
    @(negedge clk) tx_on = 1'b0;
    @(negedge clk);
    chk(dclk == 1'b0, "R6 clock low after tx_on drop", int'(dclk), 0);
    quiet(600, "R6 idle after stop");
    chk(exp_tx.size() == 0, "R5 all host bits sent", exp_tx.size(), 0);

    // Restart: header again, then stop by clearing mode bit.
    push_sync();
    @(negedge clk) tx_on = 1'b1;
    wait (sync_left == 0);
    host_tx(16'b0000_0000_0000_0110, 3);
    @(negedge clk) cfg_tx_serial = 1'b0;
    @(negedge clk);
    chk(dclk == 1'b0, "R6 clock low after mode clear", int'(dclk), 0);
    quiet(500, "R6 idle after mode clear");
    chk(exp_tx.size() == 0, "R4 second header complete", exp_tx.size(), 0);
    tx_on = 1'b0;

    // Mode decode.
    @(negedge clk) cfg_rx_serial = 1'b1;
    #1 chk(dat_oe == 1'b1, "R2 receive drives pin", int'(dat_oe), 1);
    @(negedge clk) cfg_tx_serial = 1'b1;
    #1 chk(dat_oe == 1'b0, "R2 transmit has priority", int'(dat_oe), 0);
    @(negedge clk) cfg_tx_serial = 1'b0;

    // R7: no clock before delimiter.
    quiet(800, "R7 clock idle before delimiter");
    chk(dat_out == 1'b0, "R8 data low while waiting", int'(dat_out), 0);

    rx_frame(16'b0110_1001_1100_1011, 14);
    quiet(600, "R9 idle after frame end");
    rx_frame(16'b0000_0000_0001_1010, 5);
    sfd_ind_i = 1'b1; cca_i = 1'b1; #1;
    chk(sfd_ind_o == 1 && cca_o == 1, "R10 indicators in rx", int'({sfd_ind_o, cca_o}), 3);
    chk(exp_rx.size() == 0, "R8 all received bits seen", exp_rx.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule